// File: doc/BRIEF.md
# Open-Drain Serial Shifter with Readback Collision Check

This block moves one byte at a time over a shared two-line serial bus. One line is an open-drain data wire and the other is the serial clock. Software loads a transmit byte into the shift register. The unit then sends it most significant bit first. On every rising clock edge it shifts the level actually present on the shared data wire back into that same register. When the transfer ends, the register therefore holds what the bus really carried rather than what the unit meant to send.

Before sending, software also stores the transmit byte in a separate compare register. An equality comparator between the two registers is sampled when the transfer finishes, and the result is kept as a match flag: 1 means the bus carried the byte intact, 0 means another device corrupted it. The unit either pulls the data wire low or releases it, so the idle level of the wire follows the top bit of the shift register. Loading all ones leaves the wire free for other devices. There is no arbitration: the system schedule decides which device may talk and when.

In master mode the unit makes eight clock pulses from a programmable divider and then parks the clock high. In slave mode it follows an external clock that is passed through a synchronizer. The register port is a plain write strobe with a combinational read. It has no valid/ready handshake and applies no back-pressure: a shift-register write that arrives during a transfer is dropped and flagged.

Top module: `tw_collide_shifter`

## Requirements
- R1: After reset the clock output is high, the data wire is released (sda_pull 0), busy, done, match and wr_collide are 0, the shift register reads 8'hFF and the compare register reads 8'h00.
- R2: While no transfer runs, sda_pull equals the inverse of bit 7 of the shift register, one cycle after that register last changed, so a register holding 8'hFF leaves the wire released.
- R3: In master mode the clock makes exactly 8 low pulses. Each low phase and each high phase lasts h+1 clk cycles, where h is half_div clamped to a minimum of 2. Done rises exactly 16(h+1)+1 clk cycles after the write edge, and at that point the clock is high.
- R4: The data output changes only on falling clock edges, and the bits seen at the 8 rising edges are the transmit byte, most significant bit first (sda_pull 1 means the unit drives a 0).
- R5: After a transfer the shift register holds the bits sampled from the data wire on the rising edges, which is the wired-AND of every driver: transmit byte AND NOT the bits another device pulled low.
- R6: A write with reg_sel 1 stores the compare register, which reg_sel 1 then reads back. It starts no transfer and leaves the shift register unchanged.
- R7: When done rises, match equals 1 exactly when the shift register equals the compare register. A new transfer clears match, and match is never 1 while done is 0.
- R8: A shift-register write (reg_sel 0) during a transfer is ignored: the transfer and the final register contents are unaffected. It sets wr_collide, which stays set until the next accepted shift-register write clears it.
- R9: If master_en is 0 when the transfer is written, sck_out stays high and the unit shifts on the edges of sck_in (after synchronization), with done after the 8th rising edge.
- R10: An accepted shift-register write makes busy 1 and done 0 from the next cycle. Busy falls and done rises at the end of the transfer, and done stays set until the next accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select for write and read: 0 shift register, 1 compare register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read of the selected register |
| master_en | input | 1 | 1: generate the serial clock; sampled at transfer start |
| half_div | input | 8 | Half-period divider value (clk cycles minus one, minimum 2) |
| sck_in | input | 1 | External serial clock in slave mode |
| sck_out | output | 1 | Generated serial clock, idles high |
| sda_in | input | 1 | Level of the shared data wire |
| sda_pull | output | 1 | 1 pulls the data wire low, 0 releases it |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished, match is valid |
| match | output | 1 | Latched comparator result |
| wr_collide | output | 1 | Sticky flag: shift write attempted while busy |

## Verification
With the write edge as cycle 0, busy is 1 and done and match are 0 by cycle 1. Done and match then appear together at cycle 16(h+1)+1, and the idle wire level reflects the received byte one cycle after that. The bench drives inputs on falling clk edges and counts falling edges after the write, so the done timing is an exact cycle number and not a bound. A bus model observes sck_out on falling clk edges and pulls the wire low for chosen bits one half-cycle after each serial falling edge, which lets the wired-AND result be predicted bit by bit. In slave mode the bench spaces its own sck_in edges six cycles apart, which covers the synchronizer delay, and then allows a fixed number of cycles for done.

// File: rtl/tws_pkg.sv
`timescale 1ns/1ps
package tws_pkg;
  // Register select encoding shared by the write and read paths.
  typedef enum logic {
    SEL_SHIFT = 1'b0,
    SEL_CMP   = 1'b1
  } reg_sel_e;

  // Smallest half-period count. It leaves room for the two-flop
  // data synchronizer to settle between a falling and a rising edge.
  localparam int MIN_HALF = 2;
endpackage

// File: rtl/tws_sync.sv
`timescale 1ns/1ps
module tws_sync #(
  parameter int  STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_in};
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/tws_clkgen.sv
`timescale 1ns/1ps
module tws_clkgen
  import tws_pkg::*;
#(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            run,
  input  logic [DIVW-1:0] half_div,
  output logic            sck_out,
  output logic            fall_ev,
  output logic            rise_ev
);
  localparam logic [DIVW-1:0] HALF_FLOOR = DIVW'(MIN_HALF);

  logic [DIVW-1:0] cnt_q;
  logic [DIVW-1:0] half_q;
  logic            sck_q;
  logic            tick;
  logic [DIVW-1:0] half_eff;

  assign half_eff = (half_div < HALF_FLOOR) ? HALF_FLOOR : half_div;
  assign tick     = run && (cnt_q == half_q);
  assign fall_ev  = tick && sck_q;
  assign rise_ev  = tick && !sck_q;
  assign sck_out  = sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= HALF_FLOOR;
      sck_q  <= 1'b1;
    end else if (start) begin
      cnt_q  <= '0;
      half_q <= half_eff;
      sck_q  <= 1'b1;
    end else if (run) begin
      if (tick) begin
        cnt_q <= '0;
        sck_q <= !sck_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end
  end

  // R3: a rising edge never follows its falling edge in the next cycle
  p_half_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> !rise_ev);
endmodule

// File: rtl/tws_shifter.sv
`timescale 1ns/1ps
module tws_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] wr_data,
  input  logic         mode_in,
  input  logic         fall_ev,
  input  logic         rise_ev,
  input  logic         sda_bit,
  output logic [W-1:0] shreg,
  output logic         out_bit,
  output logic         busy,
  output logic         done,
  output logic         fin,
  output logic         mode_q
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] bitcnt;
  logic          fin_q;

  assign fin = fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '1;
      busy   <= 1'b0;
      done   <= 1'b0;
      fin_q  <= 1'b0;
      bitcnt <= '0;
      mode_q <= 1'b1;
    end else begin
      fin_q <= 1'b0;
      if (start) begin
        shreg  <= wr_data;
        busy   <= 1'b1;
        done   <= 1'b0;
        bitcnt <= '0;
        mode_q <= mode_in;
      end else if (busy) begin
        if (rise_ev && !fin_q) begin
          shreg  <= {shreg[W-2:0], sda_bit};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == LAST) fin_q <= 1'b1;
        end
        if (fin_q) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // Outgoing bit: follows the register MSB when idle, moves only on falling edges when busy.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_bit <= 1'b1;
    else if (!busy)   out_bit <= shreg[W-1];
    else if (fall_ev) out_bit <= shreg[W-1];
  end

  // R4: while busy, the driven bit moves only with a falling edge
  p_out_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fall_ev) |=> $stable(out_bit));

  // R6: with no transfer and no accepted write, the shift register holds
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(shreg));
endmodule

// File: rtl/tws_cmp.sv
`timescale 1ns/1ps
module tws_cmp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_we,
  input  logic [W-1:0] wr_data,
  input  logic         start,
  input  logic         fin,
  input  logic [W-1:0] shreg,
  output logic [W-1:0] cmp_q,
  output logic         match
);
  logic equal;

  assign equal = (shreg == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_we) cmp_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     match <= 1'b0;
    else if (start) match <= 1'b0;
    else if (fin)   match <= equal;
  end

  // R7: a new transfer always clears the latched result
  p_start_clears_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !match);
endmodule

// File: rtl/tw_collide_shifter.sv
`timescale 1ns/1ps
module tw_collide_shifter
  import tws_pkg::*;
#(
  parameter int W           = 8,
  parameter int DIVW        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_sel,
  input  logic [W-1:0]    wr_data,
  output logic [W-1:0]    rd_data,
  input  logic            master_en,
  input  logic [DIVW-1:0] half_div,
  input  logic            sck_in,
  output logic            sck_out,
  input  logic            sda_in,
  output logic            sda_pull,
  output logic            busy,
  output logic            done,
  output logic            match,
  output logic            wr_collide
);
  logic         start, cmp_we, bad_wr;
  logic         sda_s, sck_s, sck_d;
  logic         m_fall, m_rise, s_fall, s_rise;
  logic         fall_ev, rise_ev;
  logic         mode_q, fin, out_bit;
  logic [W-1:0] shreg, cmp_q;

  assign start  = reg_wr && (reg_sel == SEL_SHIFT) && !busy;
  assign bad_wr = reg_wr && (reg_sel == SEL_SHIFT) && busy;
  assign cmp_we = reg_wr && (reg_sel == SEL_CMP);

  tws_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d_in(sda_in), .q_out(sda_s));
  tws_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d_in(sck_in), .q_out(sck_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b1;
    else        sck_d <= sck_s;
  end

  assign s_fall  = busy && !mode_q && sck_d && !sck_s;
  assign s_rise  = busy && !mode_q && !sck_d && sck_s;
  assign fall_ev = mode_q ? m_fall : s_fall;
  assign rise_ev = mode_q ? m_rise : s_rise;

  tws_clkgen #(.DIVW(DIVW)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .start(start), .run(busy && mode_q),
    .half_div(half_div), .sck_out(sck_out), .fall_ev(m_fall), .rise_ev(m_rise));

  tws_shifter #(.W(W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_data(wr_data),
    .mode_in(master_en), .fall_ev(fall_ev), .rise_ev(rise_ev),
    .sda_bit(sda_s), .shreg(shreg), .out_bit(out_bit), .busy(busy),
    .done(done), .fin(fin), .mode_q(mode_q));

  tws_cmp #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cmp_we(cmp_we), .wr_data(wr_data),
    .start(start), .fin(fin), .shreg(shreg), .cmp_q(cmp_q), .match(match));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wr_collide <= 1'b0;
    else if (start)  wr_collide <= 1'b0;
    else if (bad_wr) wr_collide <= 1'b1;
  end

  assign sda_pull = !out_bit;
  assign rd_data  = (reg_sel == SEL_CMP) ? cmp_q : shreg;

  // R10: an accepted write begins a transfer with done cleared
  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done));

  // R7: match is only ever reported alongside done
  p_match_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> done);

  // R8: the collision flag is sticky until a write is accepted
  p_wcol_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_collide && !start) |=> wr_collide);

  // R8: a rejected write leaves the shift register untouched
  p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_wr && !rise_ev) |=> $stable(shreg));

  // R9: slave transfers never drive the clock low
  p_slave_clock_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q) |-> sck_out);

  // R3: the clock is parked high when done rises
  p_done_clock_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> sck_out);
endmodule

// File: tb/tw_collide_shifter_bench.sv
`timescale 1ns/1ps
module tw_collide_shifter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_sel = 1'b0, master_en = 1'b1, sck_in = 1'b1;
  logic [7:0] wr_data = 8'h00, half_div = 8'd2;
  logic [7:0] rd_data;
  logic       sck_out, sda_pull, busy, done, match, wr_collide;
  logic       m_other = 1'b0, s_other = 1'b0;
  wire        line = !(sda_pull || m_other || s_other);

  int         checks = 0, errors = 0;
  logic [7:0] mask_g = 8'h00;
  int         exp_len = 3;
  logic [7:0] obs;
  int         rises, lowlen, fidx;
  bit         badlen, prev_sck = 1'b1, prev_busy = 1'b0;

  always #5 clk = !clk;

  tw_collide_shifter u_tw_collide_shifter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .master_en(master_en),
    .half_div(half_div), .sck_in(sck_in), .sck_out(sck_out), .sda_in(line),
    .sda_pull(sda_pull), .busy(busy), .done(done), .match(match),
    .wr_collide(wr_collide));

  // Bus model and observer for master transfers, sampled away from the edge.
  always @(negedge clk) begin
    if (busy && !prev_busy) begin
      obs = 8'h00; rises = 0; lowlen = 0; badlen = 1'b0;
    end
    if (!busy) begin
      fidx = 0; m_other = 1'b0;
    end else begin
      if (prev_sck && !sck_out && fidx < 8) begin
        m_other = mask_g[7-fidx];
        fidx++;
      end
      if (!sck_out) lowlen++;
      if (!prev_sck && sck_out) begin
        obs = {obs[6:0], !sda_pull};
        rises++;
        if (lowlen != exp_len) badlen = 1'b1;
        lowlen = 0;
      end
    end
    prev_sck  = sck_out;
    prev_busy = busy;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_cmp(input logic [7:0] v, input logic [7:0] sh_before);
    @(negedge clk); reg_wr = 1'b1; reg_sel = 1'b1; wr_data = v;
    @(negedge clk); reg_wr = 1'b0; #1;
    chk(rd_data == v, "R6 compare readback", rd_data, v);
    chk(!busy, "R6 compare write starts nothing", busy, 0);
    reg_sel = 1'b0; #1;
    chk(rd_data == sh_before, "R6 shift reg untouched", rd_data, sh_before);
  endtask

  logic [7:0] sh_now = 8'hFF;

  task automatic run_master(input logic [7:0] d, input logic [7:0] cmpv,
                            input logic [7:0] msk, input logic [7:0] hd, input bit hit);
    int k, h, expk;
    logic [7:0] rx;
    write_cmp(cmpv, sh_now);
    h = (hd < 2) ? 2 : int'(hd);
    expk = 16 * (h + 1) + 1;
    exp_len = h + 1; mask_g = msk; half_div = hd; master_en = 1'b1;
    @(negedge clk); reg_wr = 1'b1; reg_sel = 1'b0; wr_data = d;
    @(posedge clk);
    @(negedge clk); reg_wr = 1'b0; k = 0;
    chk(busy && !done && !match, "R10 start state", {busy, done, match}, 3'b100);
    chk(!wr_collide, "R8 cleared on accepted write", wr_collide, 0);
    while (!done && k < 400) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (hit && k == 20) begin reg_wr = 1'b1; wr_data = ~d; end
      else reg_wr = 1'b0;
    end
    reg_wr = 1'b0;
    rx = d & ~msk;
    chk(k == expk, "R3 done cycle", k, expk);
    chk(rises == 8 && !badlen, "R3 pulse count and half period", rises, 8);
    chk(obs == d, "R4 MSB-first output bits", obs, d);
    #1;
    chk(rd_data == rx, "R5 readback of wired-AND", rd_data, rx);
    chk(match == (rx == cmpv), "R7 match flag", match, (rx == cmpv));
    chk(!busy && sck_out, "R10 idle after done", {busy, sck_out}, 2'b01);
    if (hit) chk(wr_collide, "R8 collision flag set", wr_collide, 1);
    @(negedge clk);
    chk(sda_pull == !rx[7], "R2 idle line level", sda_pull, !rx[7]);
    chk(done, "R10 done holds", done, 1);
    sh_now = rx;
  endtask

  task automatic run_slave(input logic [7:0] d, input logic [7:0] cmpv, input logic [7:0] msk);
    logic [7:0] rx;
    bit clk_low_seen;
    write_cmp(cmpv, sh_now);
    master_en = 1'b0; clk_low_seen = 1'b0;
    @(negedge clk); reg_wr = 1'b1; reg_sel = 1'b0; wr_data = d;
    @(negedge clk); reg_wr = 1'b0;
    for (int i = 0; i < 8; i++) begin
      sck_in = 1'b0; s_other = msk[7-i];
      repeat (6) begin @(negedge clk); if (!sck_out) clk_low_seen = 1'b1; end
      sck_in = 1'b1;
      repeat (6) begin @(negedge clk); if (!sck_out) clk_low_seen = 1'b1; end
    end
    s_other = 1'b0;
    rx = d & ~msk;
    #1;
    chk(done && !busy, "R9 slave done after 8th rise", {done, busy}, 2'b10);
    chk(!clk_low_seen, "R9 sck_out held high", clk_low_seen, 0);
    chk(rd_data == rx, "R9 R5 slave readback", rd_data, rx);
    chk(match == (rx == cmpv), "R7 slave match", match, (rx == cmpv));
    master_en = 1'b1;
    sh_now = rx;
  endtask

  initial begin : main
    logic [7:0] d, c, m, hd;
    d = 8'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    #1;
    chk(sck_out && !sda_pull, "R1 reset lines", {sck_out, sda_pull}, 2'b10);
    chk({busy, done, match, wr_collide} == 4'b0, "R1 reset flags", {busy, done, match, wr_collide}, 0);
    chk(rd_data == 8'hFF, "R1 reset shift reg", rd_data, 8'hFF);
    reg_sel = 1'b1; #1;
    chk(rd_data == 8'h00, "R1 reset compare reg", rd_data, 8'h00);
    reg_sel = 1'b0;
    rst_n = 1'b1;

    run_master(8'h5A, 8'h5A, 8'h00, 8'd0, 1'b0);   // clamp to 2, clean
    run_master(8'h3C, 8'h3C, 8'h00, 8'd4, 1'b0);   // MSB 0 -> idle pulls low
    run_master(8'hFF, 8'hFF, 8'h24, 8'd3, 1'b0);   // collision, mismatch
    run_master(8'hFF, 8'hFF, 8'h00, 8'd2, 1'b0);   // all ones releases line
    run_master(8'hA5, 8'h00, 8'h00, 8'd1, 1'b0);   // compare differs
    run_master(8'hC3, 8'hC3, 8'h00, 8'd2, 1'b1);   // write while busy
    run_master(8'h81, 8'h81, 8'h00, 8'd2, 1'b0);   // flag cleared again
    run_slave(8'h96, 8'h96, 8'h00);
    run_slave(8'hF0, 8'hF0, 8'h30);

    for (int n = 0; n < 20; n++) begin
      d  = 8'($urandom);
      hd = 8'($urandom % 6);
      m  = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
      c  = ($urandom % 4 == 0) ? 8'($urandom) : d;
      run_master(d, c, m, hd, ($urandom % 5 == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule